// File: doc/BRIEF.md
# Two-Level Interrupt Master Aggregator

This block holds the top two levels of an interrupt tree for a device with up to four tiles. Each tile has a graphics master register. It latches summary levels from four lower sources: engine bank 0, engine bank 1, a miscellaneous unit and a display unit. A single device master register holds one indication bit per tile, a global enable bit, and drives the device interrupt line. Lower-level units are modelled as plain input levels.

Software services an interrupt in a fixed order. It writes zero to the device master to drop the line, then reads the tile indications. Next it acknowledges each tile's graphics master by writing back the value it read, then acknowledges the device master bits the same way. Last, it writes the enable bit to re-arm the line. All indication bits are sticky and write-one-to-clear. A bit that is acknowledged while its source is still active sets again on the same edge. So a source that stays pending through the handler raises the line again as soon as the master is re-enabled. The lower level must be cleared before the upper level, or the upper bit simply latches again.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A graphics master bit is set on the first clock edge at which its source level is high, and then stays set even if the source falls. Field positions per tile: bit 0 engine bank 0, bit 1 engine bank 1, bit 2 misc unit, bit 3 display unit (source index `t*4+k` maps to bit k of tile t).
- R3: Writing a graphics master register (address 1+t) clears the bits written as one. A bit whose source is still high at that edge stays set, and bits written as zero are untouched.
- R4: Device master tile bit t (bit t at address 0) is set on the edge after tile t's graphics master becomes nonzero, and sets again while that register stays nonzero.
- R5: Writing the device master clears the tile bits written as one, unless the tile's graphics master is still nonzero at that edge.
- R6: `irq_o` is high exactly when the enable bit (bit 31 of address 0, loaded from every write there) is set and any tile bit is set. A write with bit 31 clear drops `irq_o` in the next cycle, while the tile bits stay readable.
- R7: Writing bit 31 set while a source is still pending raises `irq_o` in the next cycle.
- R8: No read ever returns all ones. Bits 30 down to the tile count at address 0, and bits above 3 at graphics master addresses, read as zero.
- R9: Addresses above the tile count read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 16 | Lower-level source levels, four per tile |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | 0 = device master, 1+t = graphics master of tile t |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | 1 | Device interrupt line, level |

## Verification
The bench targets acknowledge order. If the device master is acknowledged before its graphics master, the tile bit must survive. A design that clears it anyway would lose a pending interrupt. It checks that a source held high through the whole handler re-raises the line on re-enable. A design that samples sources only on a rising edge, or clears on ack without re-latching, would stay silent there. One-cycle source pulses must be captured, and out-of-range addresses and all-ones writes must neither alter state nor yield an all-ones read. A design that decodes loosely would corrupt a tile register or echo the write data.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int SRC_PER_TILE = 4;
  localparam int EN_BIT       = 31;

  typedef enum int {
    FLD_BANK0 = 0,
    FLD_BANK1 = 1,
    FLD_MISC  = 2,
    FLD_DISP  = 3
  } gm_field_e;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] bits_o
);
  logic [W-1:0] bits_q;

  // set wins over clear: a still-active source re-latches on ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= (bits_q & ~clr_i) | set_i;
  end

  assign bits_o = bits_q;

  AST_SET_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((bits_q & $past(set_i)) == $past(set_i))); // R2

  AST_CLR_ONLY_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_q != '0) |=> ((~bits_q & $past(bits_q) & ~$past(clr_i)) == '0)); // R3
endmodule

// File: rtl/irq_tile_master.sv
module irq_tile_master
  import irq_agg_pkg::*;
#(
  parameter int N_TILES = 4,
  parameter int REG_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_TILES-1:0] gm_any_i,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic               en_o,
  output logic [N_TILES-1:0] pend_o,
  output logic               irq_o
);
  logic               en_q;
  logic [N_TILES-1:0] ack;

  assign ack = we_i ? wdata_i[N_TILES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= 1'b0;
    else if (we_i) en_q <= wdata_i[EN_BIT];
  end

  irq_w1c_bank #(.W(N_TILES)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (gm_any_i),
    .clr_i  (ack),
    .bits_o (pend_o)
  );

  assign en_o  = en_q;
  assign irq_o = en_q & (|pend_o);

  for (genvar t = 0; t < N_TILES; t++) begin : g_chk
    AST_TILE_FROM_GM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gm_any_i[t] |=> pend_o[t]); // R4
  end

  AST_DISABLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[EN_BIT]) |=> !irq_o); // R6

  AST_REARM_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[EN_BIT] && (|gm_any_i)) |=> irq_o); // R7
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int N_TILES = 4,
  parameter int REG_W   = 32,
  localparam int SRC_W  = N_TILES * SRC_PER_TILE,
  localparam int ADDR_W = $clog2(N_TILES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [N_TILES-1:0][SRC_PER_TILE-1:0] gm_q;
  logic [N_TILES-1:0]                   gm_any;
  logic [N_TILES-1:0]                   pend;
  logic                                 en;
  logic                                 top_we;
  logic                                 unused_wdata;

  assign top_we       = reg_we_i && (reg_addr_i == '0);
  assign unused_wdata = ^reg_wdata_i[EN_BIT-1:SRC_PER_TILE];

  for (genvar t = 0; t < N_TILES; t++) begin : g_tile
    logic [SRC_PER_TILE-1:0] gm_ack;
    assign gm_ack = (reg_we_i && reg_addr_i == ADDR_W'(t + 1))
                    ? reg_wdata_i[SRC_PER_TILE-1:0] : '0;

    irq_w1c_bank #(.W(SRC_PER_TILE)) u_gm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (src_i[t*SRC_PER_TILE +: SRC_PER_TILE]),
      .clr_i  (gm_ack),
      .bits_o (gm_q[t])
    );
    assign gm_any[t] = |gm_q[t];
  end

  irq_tile_master #(.N_TILES(N_TILES), .REG_W(REG_W)) u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gm_any_i (gm_any),
    .we_i     (top_we),
    .wdata_i  (reg_wdata_i),
    .en_o     (en),
    .pend_o   (pend),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == '0) begin
      reg_rdata_o[EN_BIT]      = en;
      reg_rdata_o[N_TILES-1:0] = pend;
    end else begin
      for (int t = 0; t < N_TILES; t++)
        if (reg_addr_i == ADDR_W'(t + 1)) reg_rdata_o[SRC_PER_TILE-1:0] = gm_q[t];
    end
  end

  AST_RD_NOT_ALL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o != '1); // R8

  AST_BAD_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i > ADDR_W'(N_TILES)) |-> (reg_rdata_o == '0)); // R9
endmodule

// File: tb/sim_irq_agg_top.sv
module sim_irq_agg_top;
  localparam int CLK_P = 10;
  localparam int NT    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_agg_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // expected state from the requirements
  logic [3:0] gm_m [NT];
  logic [3:0] tp_m;
  logic       en_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) gm_m[t] <= '0;
      tp_m <= '0;
      en_m <= 1'b0;
    end else begin
      for (int t = 0; t < NT; t++) begin
        gm_m[t] <= (gm_m[t] & ~((we && addr == 3'(t + 1)) ? wdata[3:0] : 4'h0))
                   | src[t*4 +: 4];
        tp_m[t] <= (tp_m[t] & ~(we && addr == 3'd0 && wdata[t])) | (gm_m[t] != 4'h0);
      end
      if (we && addr == 3'd0) en_m <= wdata[31];
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    if (a == 3'd0) return {en_m, 27'b0, tp_m};
    if (a <= 3'(NT)) return {28'b0, gm_m[a - 1]};
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk); #1;
    chk(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    idle(2);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 master", 3'd0, 32'h0);
    rd_chk("R1 gm", 3'd3, 32'h0);
    irq_chk("R1 irq", 1'b0);

    // R2/R4: tile2 bank1 source held high
    @(negedge clk); src[2*4 + 1] = 1'b1;
    idle(2);
    rd_chk("R2 gm latch", 3'd3, 32'h2);
    rd_chk("R4 tile bit", 3'd0, 32'h4);
    irq_chk("R6 no irq without enable", 1'b0);

    wr(3'd0, 32'h8000_0000);
    irq_chk("R7 enable raises", 1'b1);

    // handler sequence with the source still pending
    wr(3'd0, 32'h0);
    irq_chk("R6 disable drops", 1'b0);
    rd_chk("R6 bits readable", 3'd0, 32'h4);
    wr(3'd0, 32'h4);
    rd_chk("R5 ack kept while gm pending", 3'd0, 32'h4);
    wr(3'd3, 32'h2);
    rd_chk("R3 ack kept while source high", 3'd3, 32'h2);
    wr(3'd0, 32'h8000_0000);
    irq_chk("R7 re-raise on re-arm", 1'b1);

    // clean close: lower level first, then top
    wr(3'd0, 32'h0);
    @(negedge clk); src = '0;
    wr(3'd3, 32'h2);
    rd_chk("R3 ack clears", 3'd3, 32'h0);
    rd_chk("R4 tile bit held until ack", 3'd0, 32'h4);
    wr(3'd0, 32'h4);
    rd_chk("R5 ack clears", 3'd0, 32'h0);
    wr(3'd0, 32'h8000_0000);
    irq_chk("R6 enabled, nothing pending", 1'b0);

    // R9 out-of-range
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk("R9 bad addr reads zero", 3'd5, 32'h0);
    rd_chk("R9 master untouched", 3'd0, 32'h8000_0000);
    rd_chk("R9 gm untouched", 3'd1, 32'h0);

    // R2 one-cycle pulse on tile0 misc
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk); src[2] = 1'b0;
    idle(1);
    rd_chk("R2 pulse captured", 3'd1, 32'h4);
    irq_chk("R7 pulse raises irq", 1'b1);

    // R8 all ones
    @(negedge clk); src = 16'hFFFF;
    wr(3'd0, 32'hFFFF_FFF0);
    idle(2);
    rd_chk("R8 master no all-ones", 3'd0, 32'h8000_000F);
    rd_chk("R2 all fields tile3", 3'd4, 32'hF);
    rd(3'd2, d);
    chk("R8 gm not all ones", {31'b0, d == 32'hFFFF_FFFF}, 32'h0);

    // random phase against the expected model
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [2:0] a;
      op = int'($urandom % 4);
      @(negedge clk);
      src = (($urandom % 3) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      a = 3'($urandom % 8);
      if (op == 0) begin
        wr(a, $urandom);
      end else if (op == 1) begin
        rd(a, d);
        chk(a == 3'd0 ? "R5 rand master" : (a <= 3'(NT) ? "R3 rand gm" : "R9 rand bad"),
            d, exp_rd(a));
        chk("R6 rand irq", {31'b0, irq}, {31'b0, en_m & (|tp_m)});
      end
    end
    finish_run();
  end
endmodule